// File: doc/BRIEF.md
# Eight-Queue Strict/Deficit Work-Queue Scheduler

This block picks which of the eight work queues of one channel may hand out its next frame. Every queue reports whether it holds data and the byte length of the frame at its head. A per-queue configuration bit puts the queue either in the strict class or in the weighted class, and it may be changed while traffic runs. Strict queues always win over weighted ones. Among weighted queues, service is shared by bytes, not by frames, using a deficit counter per queue and a round-robin pointer.

The result is presented as a queue index with a valid strobe. It is held until the consumer accepts it with a single-cycle accept. The consumer then pops that queue's head frame, so the queue's new state is visible on the next cycle. Each weighted queue has an 8-bit weight, and its quantum is the weight times 64 bytes. The weighted arbiter takes one step per cycle: it either grants the queue under the pointer or moves the pointer on. A weighted queue whose frames are much larger than its quantum therefore collects credit over several rounds.

Top module: `wq_scheduler`

## Requirements
- R1: After reset no grant is presented, every deficit counter is zero, the round-robin pointer is on queue 0, and the next turn of the pointed queue begins with a fresh quantum.
- R2: When no grant is outstanding and any queue is both non-empty and strict (cfg_strict bit = 1), the next grant goes to the lowest-index queue of that set, one cycle later.
- R3: Weighted queues (cfg_strict bit = 0) are considered only in a cycle where no strict queue is non-empty. Queued weighted data is eventually served once the strict class has drained.
- R4: At the first step of a weighted queue's turn its deficit is raised by weight × 64 bytes. Whenever the raised or carried deficit is at least the head frame length, that queue is granted and the length is subtracted.
- R5: When the pointed weighted queue's deficit does not cover its head frame, the deficit is kept. The pointer then moves to the next non-empty weighted queue in ascending circular order, whose turn starts fresh. If the pointed queue is empty, the pointer likewise moves on with no grant.
- R6: The deficit of a queue that is empty or configured strict is cleared to zero. A queue that drains and refills restarts with no credit.
- R7: While grant_valid is high and deq_accept is low, grant_valid stays high and grant_idx does not change.
- R8: A cycle with grant_valid and deq_accept both high ends that grant. grant_valid is low in the next cycle, and a new decision is made in that cycle from the updated queue state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| q_nonempty | input | NQ | Bit i set when queue i holds at least one frame |
| q_head_len | input | NQ*LEN_W | Head frame byte length of queue i in bits [i*LEN_W +: LEN_W] |
| cfg_strict | input | NQ | Bit i: 1 = queue i strict class, 0 = weighted class |
| cfg_weight | input | NQ*WT_W | Weight of queue i in bits [i*WT_W +: WT_W]; quantum is weight × 64 bytes |
| deq_accept | input | 1 | Consumer takes the presented grant this cycle |
| grant_valid | output | 1 | A grant is presented |
| grant_idx | output | IDX_W | Binary index of the granted queue |

## Verification
Some properties are checked on every cycle by assertions. These are the handshake rules: a held grant stays stable, and an accepted grant drops. They also cover the strict rule that a fresh grant goes to the lowest non-empty strict queue, and the clearing of the deficit of any empty or strict queue. The byte-based sharing between weighted queues is only visible over many grants, and so is the carry-over of credit across turns. The same holds for the effect of a mid-run mode change and for restarting with no credit after a drain. These are shown by the bench's scenarios, where a behavioural model tracks the queues and credit and is compared with the outputs on every clock.

// File: rtl/wq_sched_pkg.sv
`timescale 1ns/1ps
package wq_sched_pkg;
   // bytes granted per unit of weight, as a left shift (64 bytes)
   localparam int QUANTUM_SHIFT = 6;

   // per-queue class encoding on cfg_strict
   typedef enum logic {
      WQ_WEIGHTED = 1'b0,
      WQ_STRICT   = 1'b1
   } wq_class_e;

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/wq_sched_pick.sv
`timescale 1ns/1ps
// Finds the first set request bit, searching upward from 'start' with wrap.
module wq_sched_pick #(
   parameter int N  = 8,
   parameter int IW = 3
) (
   input  logic [N-1:0]  req,
   input  logic [IW-1:0] start,
   output logic          found,
   output logic [IW-1:0] idx
);
   if (N < 2) begin : g_bad_n
      $error("wq_sched_pick: N must be at least 2");
   end
   if ((1 << IW) < N) begin : g_bad_iw
      $error("wq_sched_pick: IW too narrow for N");
   end

   always_comb begin
      found = 1'b0;
      idx   = '0;
      // scan from the far end so the nearest candidate is written last
      for (int k = N - 1; k >= 0; k--) begin
         int j;
         j = (int'(start) + k) % N;
         if (req[j]) begin
            found = 1'b1;
            idx   = IW'(j);
         end
      end
   end
endmodule

// File: rtl/wq_sched_deficit.sv
`timescale 1ns/1ps
// One byte-credit counter for a weighted queue.
module wq_sched_deficit #(
   parameter int LEN_W = 14,
   parameter int WT_W  = 8,
   parameter int QSH   = 6,
   parameter int DEF_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             eligible,   // non-empty and weighted
   input  logic             step,       // pointer is here and the fair arbiter acts
   input  logic             fresh,      // turn begins: add the quantum
   input  logic [WT_W-1:0]  weight,
   input  logic [LEN_W-1:0] head_len,
   output logic             covers
);
   if (DEF_W <= LEN_W || DEF_W <= WT_W + QSH) begin : g_bad_def
      $error("wq_sched_deficit: DEF_W cannot hold credit plus one quantum");
   end

   logic [DEF_W-1:0] credit_q;
   logic [DEF_W-1:0] quantum;
   logic [DEF_W-1:0] eff;

   assign quantum = DEF_W'(weight) << QSH;
   assign eff     = credit_q + (fresh ? quantum : '0);
   assign covers  = (eff >= DEF_W'(head_len));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         credit_q <= '0;
      end else if (!eligible) begin
         credit_q <= '0;
      end else if (step) begin
         credit_q <= covers ? (eff - DEF_W'(head_len)) : eff;
      end
   end

   // R6: an empty or strict queue holds no credit on the following cycle
   a_r6_clear_when_ineligible: assert property (@(posedge clk) disable iff (!rst_n)
      !eligible |=> (credit_q == '0));
endmodule

// File: rtl/wq_scheduler.sv
`timescale 1ns/1ps
module wq_scheduler #(
   parameter int NQ    = 8,
   parameter int LEN_W = 14,
   parameter int WT_W  = 8,
   localparam int IDX_W = (NQ > 1) ? $clog2(NQ) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NQ-1:0]      q_nonempty,
   input  logic [NQ*LEN_W-1:0] q_head_len,
   input  logic [NQ-1:0]      cfg_strict,
   input  logic [NQ*WT_W-1:0] cfg_weight,
   input  logic               deq_accept,
   output logic               grant_valid,
   output logic [IDX_W-1:0]   grant_idx
);
   import wq_sched_pkg::*;

   localparam int QSH   = QUANTUM_SHIFT;
   localparam int DEF_W = max_int(LEN_W, WT_W + QSH) + 1;

   if (NQ < 2) begin : g_bad_nq
      $error("wq_scheduler: NQ must be at least 2");
   end
   if (LEN_W < 1 || WT_W < 1) begin : g_bad_w
      $error("wq_scheduler: LEN_W and WT_W must be positive");
   end

   logic [NQ-1:0]    strict_req;
   logic [NQ-1:0]    fair_req;
   logic [NQ-1:0]    cover_vec;
   logic             s_found, n_found;
   logic [IDX_W-1:0] s_idx, n_idx;
   logic [IDX_W-1:0] rr_ptr_q, next_start;
   logic             fresh_q;
   logic             valid_q;
   logic [IDX_W-1:0] idx_q;
   logic             slot_free, fair_step, fair_skip, issue_strict, issue_fair;

   for (genvar i = 0; i < NQ; i++) begin : g_req
      assign strict_req[i] = q_nonempty[i] && (cfg_strict[i] == WQ_STRICT);
      assign fair_req[i]   = q_nonempty[i] && (cfg_strict[i] == WQ_WEIGHTED);
   end

   assign next_start = (rr_ptr_q == IDX_W'(NQ - 1)) ? '0 : rr_ptr_q + 1'b1;

   wq_sched_pick #(.N(NQ), .IW(IDX_W)) u_strict_pick (
      .req(strict_req), .start('0), .found(s_found), .idx(s_idx));

   wq_sched_pick #(.N(NQ), .IW(IDX_W)) u_rr_pick (
      .req(fair_req), .start(next_start), .found(n_found), .idx(n_idx));

   assign slot_free    = !valid_q;
   assign issue_strict = slot_free && s_found;
   assign fair_step    = slot_free && !s_found && fair_req[rr_ptr_q];
   assign fair_skip    = slot_free && !s_found && !fair_req[rr_ptr_q] && n_found;
   assign issue_fair   = fair_step && cover_vec[rr_ptr_q];

   for (genvar i = 0; i < NQ; i++) begin : g_cell
      wq_sched_deficit #(.LEN_W(LEN_W), .WT_W(WT_W), .QSH(QSH), .DEF_W(DEF_W)) u_credit (
         .clk      (clk),
         .rst_n    (rst_n),
         .eligible (fair_req[i]),
         .step     (fair_step && (rr_ptr_q == IDX_W'(i))),
         .fresh    (fresh_q),
         .weight   (cfg_weight[i*WT_W +: WT_W]),
         .head_len (q_head_len[i*LEN_W +: LEN_W]),
         .covers   (cover_vec[i])
      );
   end

   // round-robin pointer and turn state
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rr_ptr_q <= '0;
         fresh_q  <= 1'b1;
      end else if (issue_fair) begin
         fresh_q <= 1'b0;
      end else if (fair_step || fair_skip) begin
         rr_ptr_q <= n_idx;
         fresh_q  <= 1'b1;
      end
   end

   // grant register with accept handshake
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         idx_q   <= '0;
      end else if (valid_q) begin
         if (deq_accept) valid_q <= 1'b0;
      end else if (issue_strict) begin
         valid_q <= 1'b1;
         idx_q   <= s_idx;
      end else if (issue_fair) begin
         valid_q <= 1'b1;
         idx_q   <= rr_ptr_q;
      end
   end

   assign grant_valid = valid_q;
   assign grant_idx   = idx_q;

   // R7: an unaccepted grant is held unchanged
   a_r7_hold_until_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid && !deq_accept) |=> (grant_valid && $stable(grant_idx)));

   // R8: an accepted grant is withdrawn on the next cycle
   a_r8_drop_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid && deq_accept) |=> !grant_valid);

   // R2: a new grant with a strict request pending names the lowest strict queue
   a_r2_lowest_strict_first: assert property (@(posedge clk) disable iff (!rst_n)
      (!grant_valid && (strict_req != '0)) |=>
         (grant_valid
          && (($past(strict_req) & (NQ'(1) << grant_idx)) != '0)
          && (($past(strict_req) & ((NQ'(1) << grant_idx) - NQ'(1))) == '0)));
endmodule

// File: tb/wq_scheduler_tb_top.sv
`timescale 1ns/1ps
module wq_scheduler_tb_top;
   localparam int NQ    = 8;
   localparam int LEN_W = 14;
   localparam int WT_W  = 8;
   localparam int IDX_W = 3;

   logic                  clk = 1'b0;
   logic                  rst_n = 1'b0;
   logic [NQ-1:0]         q_nonempty = '0;
   logic [NQ*LEN_W-1:0]   q_head_len = '0;
   logic [NQ-1:0]         cfg_strict = '0;
   logic [NQ*WT_W-1:0]    cfg_weight = '0;
   logic                  deq_accept = 1'b0;
   logic                  grant_valid;
   logic [IDX_W-1:0]      grant_idx;

   always #10 clk = ~clk;   // 50 MHz

   wq_scheduler #(.NQ(NQ), .LEN_W(LEN_W), .WT_W(WT_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .q_nonempty(q_nonempty), .q_head_len(q_head_len),
      .cfg_strict(cfg_strict), .cfg_weight(cfg_weight), .deq_accept(deq_accept),
      .grant_valid(grant_valid), .grant_idx(grant_idx));

   // bench-side frame queues, configuration and reference state
   int fq[NQ][$];
   int wt[NQ];
   bit st[NQ];
   int m_def[NQ];
   int m_ptr = 0;
   bit m_fresh = 1'b1;
   bit m_valid = 1'b0;
   int m_idx = 0;
   bit pend_pop = 1'b0;
   int pend_idx = 0;
   int gcount[NQ];
   int total_grants = 0;
   int checks = 0;
   int fails = 0;
   int cyc = 0;
   bit done = 1'b0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int next_fair(input int p, input bit [NQ-1:0] fair);
      for (int k = 1; k <= NQ; k++) begin
         if (fair[(p + k) % NQ]) return (p + k) % NQ;
      end
      return p;
   endfunction

   task automatic drive_inputs();
      for (int i = 0; i < NQ; i++) begin
         q_nonempty[i] = (fq[i].size() > 0);
         q_head_len[i*LEN_W +: LEN_W] = (fq[i].size() > 0) ? LEN_W'(fq[i][0]) : '0;
         cfg_strict[i] = st[i];
         cfg_weight[i*WT_W +: WT_W] = WT_W'(wt[i]);
      end
   endtask

   task automatic model_step(input bit acc);
      bit [NQ-1:0] fair;
      int nd[NQ];
      int s;
      for (int i = 0; i < NQ; i++) begin
         fair[i] = (fq[i].size() > 0) && !st[i];
         nd[i] = m_def[i];
      end
      if (m_valid) begin
         if (acc) m_valid = 1'b0;
      end else begin
         s = -1;
         for (int i = NQ - 1; i >= 0; i--)
            if (fq[i].size() > 0 && st[i]) s = i;
         if (s >= 0) begin
            m_valid = 1'b1;
            m_idx = s;
         end else if (fair[m_ptr]) begin
            int eff;
            eff = m_def[m_ptr] + (m_fresh ? wt[m_ptr] * 64 : 0);
            if (eff >= fq[m_ptr][0]) begin
               nd[m_ptr] = eff - fq[m_ptr][0];
               m_valid = 1'b1;
               m_idx = m_ptr;
               m_fresh = 1'b0;
            end else begin
               nd[m_ptr] = eff;
               m_ptr = next_fair(m_ptr, fair);
               m_fresh = 1'b1;
            end
         end else if (fair != '0) begin
            m_ptr = next_fair(m_ptr, fair);
            m_fresh = 1'b1;
         end
      end
      for (int i = 0; i < NQ; i++) if (!fair[i]) nd[i] = 0;
      m_def = nd;
   endtask

   // mode 0: always accept, 1: accept every third cycle, 2: never accept
   task automatic cycle(input string req, input int mode);
      bit acc;
      @(negedge clk);
      check(grant_valid == m_valid, req, "grant_valid", grant_valid, m_valid);
      if (m_valid) check(int'(grant_idx) == m_idx, req, "grant_idx", grant_idx, m_idx);
      if (pend_pop) begin
         void'(fq[pend_idx].pop_front());
         gcount[pend_idx]++;
         total_grants++;
         pend_pop = 1'b0;
      end
      acc = (mode == 0) ? 1'b1 : (mode == 1) ? (cyc % 3 == 0) : 1'b0;
      cyc++;
      deq_accept = acc;
      drive_inputs();
      if (m_valid && acc) begin
         pend_pop = 1'b1;
         pend_idx = m_idx;
      end
      model_step(acc);
   endtask

   task automatic run(input string req, input int mode, input int n);
      for (int i = 0; i < n; i++) cycle(req, mode);
   endtask

   function automatic bit all_empty();
      for (int i = 0; i < NQ; i++) if (fq[i].size() > 0) return 1'b0;
      return 1'b1;
   endfunction

   initial begin
      int seed;
      int g;
      for (int i = 0; i < NQ; i++) begin
         wt[i] = 1; st[i] = 1'b0; m_def[i] = 0; gcount[i] = 0;
      end
      drive_inputs();

      // R1: reset state
      repeat (3) begin
         @(negedge clk);
         check(grant_valid == 1'b0, "R1", "grant_valid in reset", grant_valid, 0);
      end
      rst_n = 1'b1;
      run("R1", 0, 4);

      // R4: byte fairness, q0 32-byte frames vs q1 64-byte frames, both weight 1
      for (int i = 0; i < 12; i++) fq[0].push_back(32);
      for (int i = 0; i < 6; i++)  fq[1].push_back(64);
      g = 0;
      while (total_grants < 9 && g < 300) begin
         cycle("R4", 0);
         g++;
      end
      check(gcount[0] == 6, "R4", "q0 grants of first 9", gcount[0], 6);
      check(gcount[1] == 3, "R4", "q1 grants of first 9", gcount[1], 3);
      run("R5", 0, 60);
      check(all_empty(), "R3", "weighted backlog drained", 0, 1);

      // R2/R3: strict before weighted, lowest strict index first
      st[5] = 1'b1; st[2] = 1'b1;
      for (int i = 0; i < 3; i++) fq[5].push_back(50);
      for (int i = 0; i < 2; i++) fq[2].push_back(50);
      for (int i = 0; i < 2; i++) fq[0].push_back(40);
      g = 0;
      cycle("R2", 1);
      while (!grant_valid && g < 10) begin
         cycle("R2", 1);
         g++;
      end
      check(grant_valid && grant_idx == 3'd2, "R2", "first strict grant", grant_idx, 2);
      run("R3", 1, 80);
      check(fq[0].size() == 0, "R3", "weighted q0 served after strict", fq[0].size(), 0);
      st[5] = 1'b0; st[2] = 1'b0;
      run("R3", 0, 4);

      // R7/R8: hold without accept, then release
      wt[6] = 255;
      fq[6].push_back(10);
      fq[6].push_back(10);
      run("R7", 2, 12);
      check(grant_valid && grant_idx == 3'd6, "R7", "held grant", grant_idx, 6);
      run("R8", 0, 12);

      // R6: credit cleared on drain; R5: credit carried across turns
      wt[3] = 1;
      fq[3].push_back(100);
      run("R5", 0, 20);
      fq[3].push_back(90);
      run("R6", 0, 20);
      wt[4] = 4;
      fq[3].push_back(200); fq[3].push_back(200);
      for (int i = 0; i < 3; i++) fq[4].push_back(100);
      run("R6", 1, 15);
      st[3] = 1'b1;
      run("R6", 1, 40);
      st[3] = 1'b0;
      run("R6", 1, 40);

      // R5: mixed lengths and weights, one strict queue
      seed = 12345;
      for (int i = 0; i < NQ; i++) begin
         wt[i] = i * 10 + 3;
         for (int k = 0; k < 6; k++) begin
            seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
            fq[i].push_back(1 + (seed % 1500));
         end
      end
      st[7] = 1'b1;
      g = 0;
      while (!all_empty() && g < 4000) begin
         cycle("R5", 1);
         g++;
      end
      run("R5", 1, 10);
      check(all_empty(), "R5", "all queues drained", 0, 1);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog run did not complete actual=0 expected=1");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule